// File: doc/BRIEF.md
# Operand-Waiting Issue Buffer

This block is a small pool of issue slots placed in front of a single execution unit in an out-of-order core. Rename and dispatch logic writes an operation into a free slot. For each of the two source operands, dispatch provides either the value itself or the tag of the producer that will later supply it. Finished results arrive on a shared result bus as a tag and value pair. Every slot compares its outstanding tags against that pair and copies in any value it was waiting for.

A slot becomes eligible once both operands hold values. When more than one slot is eligible, the slot that was written earliest goes to the execution unit. One slot is sent per cycle, and sending a slot frees it. The block raises a full flag when no slot is free, and a write attempted while full is dropped. Operands are named by producer tag and not by architectural register, so several slots that target the same destination never delay one another. A flush input empties every slot at once.

Top module: `rs_station`

## Requirements
- R1: Straight after reset no slot is occupied: `full_o` is 0 and `issue_valid_o` is 0.
- R2: A write whose two operands are both marked ready is sent one cycle later. The cycle after the write, `issue_valid_o` is 1 and `issue_op_o`, `issue_a_o`, `issue_b_o` and `issue_dst_o` equal the written op, values and destination tag.
- R3: A waiting operand captures `cdb_val_i` in a cycle where `cdb_valid_i` is 1 and `cdb_tag_i` equals its tag. A broadcast whose tag differs leaves it waiting. An entry made ready this way can be sent in the next cycle.
- R4: A slot is sent only when both of its operands hold values. One captured operand out of two is not enough.
- R5: If the tag a write waits on is broadcast in the same cycle as the write, the value is captured as part of the write. The entry can then be sent in the next cycle.
- R6: When several slots are eligible, the one written earliest is sent, and at most one slot is sent per cycle.
- R7: Sending a slot frees it, so each accepted write is sent exactly once.
- R8: `full_o` is 1 exactly when all DEPTH slots are occupied. A write presented while `full_o` is 1 is dropped and is never sent.
- R9: A cycle with `flush_i` at 1 empties every slot. A write in that same cycle is dropped, and `issue_valid_o` is 0 during it.
- R10: A single broadcast wakes every slot waiting on that tag. Slots that share a destination tag are held and sent independently, with no stall between them.

Top module parameters are DEPTH (slots, default 4), TAG_W (4), DATA_W (16) and OP_W (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty all slots |
| alloc_valid_i | input | 1 | Write request from dispatch |
| alloc_op_i | input | OP_W | Operation code to hold |
| alloc_dst_i | input | TAG_W | Tag the result will carry |
| alloc_a_rdy_i | input | 1 | Operand A value is present |
| alloc_a_tag_i | input | TAG_W | Producer tag of operand A |
| alloc_a_val_i | input | DATA_W | Value of operand A |
| alloc_b_rdy_i | input | 1 | Operand B value is present |
| alloc_b_tag_i | input | TAG_W | Producer tag of operand B |
| alloc_b_val_i | input | DATA_W | Value of operand B |
| cdb_valid_i | input | 1 | Result bus carries a result |
| cdb_tag_i | input | TAG_W | Producer tag on the result bus |
| cdb_val_i | input | DATA_W | Value on the result bus |
| full_o | output | 1 | No free slot |
| issue_valid_o | output | 1 | A slot is sent this cycle |
| issue_op_o | output | OP_W | Op of the sent slot |
| issue_a_o | output | DATA_W | Operand A of the sent slot |
| issue_b_o | output | DATA_W | Operand B of the sent slot |
| issue_dst_o | output | TAG_W | Destination tag of the sent slot |

## Verification
Directed sequences cover several cases: a write that is ready at once; a broadcast with the wrong tag followed by the right one; a write whose tag is broadcast in the same cycle; one operand woken while the other still waits; three slots woken together by one tag and sharing a destination; a pool that is full and gets one more write; and a flush that coincides with a write. Each case separates a single behaviour (capture, eligibility, age order, blocking, clearing) from the others. Random traffic then draws tags from a small set so that broadcasts often match, and mixes in writes, results and rare flushes. A reference model computes the full flag and the sent slot for every cycle, comparing every field.

// File: rtl/rs_pkg.sv
`timescale 1ns/100ps
package rs_pkg;
    // default geometry of the issue buffer
    parameter int unsigned RS_DEPTH_DEF  = 4;
    parameter int unsigned RS_TAG_W_DEF  = 4;
    parameter int unsigned RS_DATA_W_DEF = 16;
    parameter int unsigned RS_OP_W_DEF   = 4;
endpackage

// File: rtl/rs_operand_wake.sv
`timescale 1ns/100ps
// Tag compare and capture for one source operand.
module rs_operand_wake #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              rdy_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_val_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] val_o
);
    logic hit;

    always_comb begin
        hit   = !rdy_i && cdb_valid_i && (cdb_tag_i == tag_i);
        rdy_o = rdy_i || hit;
        val_o = hit ? cdb_val_i : val_i;
    end
endmodule

// File: rtl/rs_pick_lowest.sv
`timescale 1ns/100ps
// Index of the lowest set bit of a vector.
module rs_pick_lowest #(
    parameter int unsigned WIDTH = 4,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |vec_i;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rs_age_order.sv
`timescale 1ns/100ps
// Relative age of the slots; grants the oldest requester.
module rs_age_order #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en_i,
    input  logic [IDX_W-1:0] alloc_idx_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] req_i,
    output logic [DEPTH-1:0] grant_o
);
    // older_q[j][i] set: slot j was written before slot i
    logic [DEPTH-1:0][DEPTH-1:0] older_d, older_q;

    always_comb begin
        older_d = older_q;
        if (alloc_en_i) begin
            for (int j = 0; j < DEPTH; j++) begin
                older_d[alloc_idx_i][j] = 1'b0;
                older_d[j][alloc_idx_i] = (IDX_W'(j) != alloc_idx_i) && valid_i[j];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req_i[j] && older_q[j][i]) blocked = 1'b1;
            end
            grant_o[i] = req_i[i] && !blocked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
endmodule

// File: rtl/rs_station.sv
`timescale 1ns/100ps
// Issue buffer with tag wake-up from the result bus.
module rs_station
    import rs_pkg::*;
#(
    parameter int unsigned DEPTH  = RS_DEPTH_DEF,
    parameter int unsigned TAG_W  = RS_TAG_W_DEF,
    parameter int unsigned DATA_W = RS_DATA_W_DEF,
    parameter int unsigned OP_W   = RS_OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_valid_i,
    input  logic [OP_W-1:0]   alloc_op_i,
    input  logic [TAG_W-1:0]  alloc_dst_i,
    input  logic              alloc_a_rdy_i,
    input  logic [TAG_W-1:0]  alloc_a_tag_i,
    input  logic [DATA_W-1:0] alloc_a_val_i,
    input  logic              alloc_b_rdy_i,
    input  logic [TAG_W-1:0]  alloc_b_tag_i,
    input  logic [DATA_W-1:0] alloc_b_val_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_val_i,
    output logic              full_o,
    output logic              issue_valid_o,
    output logic [OP_W-1:0]   issue_op_o,
    output logic [DATA_W-1:0] issue_a_o,
    output logic [DATA_W-1:0] issue_b_o,
    output logic [TAG_W-1:0]  issue_dst_o
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic              a_rdy;
        logic [TAG_W-1:0]  a_tag;
        logic [DATA_W-1:0] a_val;
        logic              b_rdy;
        logic [TAG_W-1:0]  b_tag;
        logic [DATA_W-1:0] b_val;
    } slot_t;

    slot_t [DEPTH-1:0] slot_d, slot_q;

    logic [DEPTH-1:0]  valid_vec, req_vec, grant_vec;
    logic [DEPTH-1:0]  a_rdy_w, b_rdy_w;
    logic [DATA_W-1:0] a_val_w [DEPTH];
    logic [DATA_W-1:0] b_val_w [DEPTH];
    logic              new_a_rdy, new_b_rdy;
    logic [DATA_W-1:0] new_a_val, new_b_val;
    logic [IDX_W-1:0]  free_idx;
    logic              free_any, do_alloc;

    // wake-up compare for every held operand
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rs_operand_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_a (
            .rdy_i(slot_q[g].a_rdy), .tag_i(slot_q[g].a_tag), .val_i(slot_q[g].a_val),
            .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
            .rdy_o(a_rdy_w[g]), .val_o(a_val_w[g]));
        rs_operand_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_b (
            .rdy_i(slot_q[g].b_rdy), .tag_i(slot_q[g].b_tag), .val_i(slot_q[g].b_val),
            .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
            .rdy_o(b_rdy_w[g]), .val_o(b_val_w[g]));
        assign valid_vec[g] = slot_q[g].valid;
        assign req_vec[g]   = slot_q[g].valid && slot_q[g].a_rdy && slot_q[g].b_rdy;
    end

    // capture on the write path when the producer broadcasts in the same cycle
    rs_operand_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_new_a (
        .rdy_i(alloc_a_rdy_i), .tag_i(alloc_a_tag_i), .val_i(alloc_a_val_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
        .rdy_o(new_a_rdy), .val_o(new_a_val));
    rs_operand_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_new_b (
        .rdy_i(alloc_b_rdy_i), .tag_i(alloc_b_tag_i), .val_i(alloc_b_val_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
        .rdy_o(new_b_rdy), .val_o(new_b_val));

    rs_pick_lowest #(.WIDTH(DEPTH)) u_free (
        .vec_i(~valid_vec), .idx_o(free_idx), .any_o(free_any));

    assign full_o   = !free_any;
    assign do_alloc = alloc_valid_i && free_any && !flush_i;

    rs_age_order #(.DEPTH(DEPTH)) u_age (
        .clk(clk), .rst_n(rst_n), .alloc_en_i(do_alloc), .alloc_idx_i(free_idx),
        .valid_i(valid_vec), .req_i(req_vec), .grant_o(grant_vec));

    // issue mux over the one-hot grant
    always_comb begin
        issue_valid_o = (|grant_vec) && !flush_i;
        issue_op_o    = '0;
        issue_a_o     = '0;
        issue_b_o     = '0;
        issue_dst_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant_vec[i]) begin
                issue_op_o  = slot_q[i].op;
                issue_a_o   = slot_q[i].a_val;
                issue_b_o   = slot_q[i].b_val;
                issue_dst_o = slot_q[i].dst;
            end
        end
    end

    // next state of every slot
    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i].a_rdy = a_rdy_w[i];
            slot_d[i].a_val = a_val_w[i];
            slot_d[i].b_rdy = b_rdy_w[i];
            slot_d[i].b_val = b_val_w[i];
            if (grant_vec[i]) slot_d[i].valid = 1'b0;
            if (do_alloc && free_idx == IDX_W'(i)) begin
                slot_d[i].valid = 1'b1;
                slot_d[i].op    = alloc_op_i;
                slot_d[i].dst   = alloc_dst_i;
                slot_d[i].a_rdy = new_a_rdy;
                slot_d[i].a_tag = alloc_a_tag_i;
                slot_d[i].a_val = new_a_val;
                slot_d[i].b_rdy = new_b_rdy;
                slot_d[i].b_tag = alloc_b_tag_i;
                slot_d[i].b_val = new_b_val;
            end
            if (flush_i) slot_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_vec == '0));

    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && full_o && !flush_i && !issue_valid_o) |=> $stable(valid_vec));

    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !full_o && !flush_i && !issue_valid_o)
        |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

    // R7
    issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !alloc_valid_i)
        |=> ($countones(valid_vec) + 1 == $countones($past(valid_vec))));
endmodule

// File: tb/rs_station_test.sv
`timescale 1ns/100ps
module rs_station_test;
    localparam int D  = 4;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic al_v = 1'b0;
    logic [OW-1:0] al_op = '0;
    logic [TW-1:0] al_dst = '0;
    logic al_ar = 1'b0, al_br = 1'b0;
    logic [TW-1:0] al_at = '0, al_bt = '0;
    logic [DW-1:0] al_av = '0, al_bv = '0;
    logic cdb_v = 1'b0;
    logic [TW-1:0] cdb_t = '0;
    logic [DW-1:0] cdb_d = '0;
    logic full, iss_v;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_a, iss_b;
    logic [TW-1:0] iss_dst;

    int checks = 0;
    int errors = 0;
    int seq_ctr = 0;

    always #2.5 clk = ~clk;

    rs_station #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .alloc_valid_i(al_v), .alloc_op_i(al_op), .alloc_dst_i(al_dst),
        .alloc_a_rdy_i(al_ar), .alloc_a_tag_i(al_at), .alloc_a_val_i(al_av),
        .alloc_b_rdy_i(al_br), .alloc_b_tag_i(al_bt), .alloc_b_val_i(al_bv),
        .cdb_valid_i(cdb_v), .cdb_tag_i(cdb_t), .cdb_val_i(cdb_d),
        .full_o(full), .issue_valid_o(iss_v), .issue_op_o(iss_op),
        .issue_a_o(iss_a), .issue_b_o(iss_b), .issue_dst_o(iss_dst));

    // reference model of the slots, kept from the requirements
    typedef struct {
        bit v; int seq;
        logic [OW-1:0] op; logic [TW-1:0] dst;
        bit ar; logic [TW-1:0] at; logic [DW-1:0] av;
        bit br; logic [TW-1:0] bt; logic [DW-1:0] bv;
    } ment_t;
    ment_t m [D];

    function automatic int m_count();
        int n = 0;
        for (int i = 0; i < D; i++) if (m[i].v) n++;
        return n;
    endfunction

    function automatic int m_oldest();
        int best = -1;
        for (int i = 0; i < D; i++)
            if (m[i].v && m[i].ar && m[i].br && (best < 0 || m[i].seq < m[best].seq)) best = i;
        return best;
    endfunction

    task automatic chk(string lbl, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
        end
    endtask

    task automatic idle();
        al_v = 1'b0; cdb_v = 1'b0; flush = 1'b0;
    endtask

    task automatic put_alloc(logic [OW-1:0] op, logic [TW-1:0] dst,
                             bit ar, logic [TW-1:0] at, logic [DW-1:0] av,
                             bit br, logic [TW-1:0] bt, logic [DW-1:0] bv);
        al_v = 1'b1; al_op = op; al_dst = dst;
        al_ar = ar; al_at = at; al_av = av;
        al_br = br; al_bt = bt; al_bv = bv;
    endtask

    task automatic put_cdb(logic [TW-1:0] t, logic [DW-1:0] d);
        cdb_v = 1'b1; cdb_t = t; cdb_d = d;
    endtask

    // one clock: compare outputs against the model, then advance the model
    task automatic step(string lbl);
        int e, cnt, slot;
        #2;
        cnt = m_count();
        e = flush ? -1 : m_oldest();
        chk(lbl, "full", 64'(full), 64'(cnt == D));
        chk(lbl, "issue_valid", 64'(iss_v), 64'(e >= 0));
        if (e >= 0 && iss_v === 1'b1)
            chk(lbl, "issue fields", 64'({iss_op, iss_a, iss_b, iss_dst}),
                64'({m[e].op, m[e].av, m[e].bv, m[e].dst}));
        @(posedge clk);
        if (e >= 0) m[e].v = 0;
        for (int i = 0; i < D; i++) begin
            if (m[i].v && cdb_v) begin
                if (!m[i].ar && m[i].at == cdb_t) begin m[i].ar = 1; m[i].av = cdb_d; end
                if (!m[i].br && m[i].bt == cdb_t) begin m[i].br = 1; m[i].bv = cdb_d; end
            end
        end
        if (flush) begin
            for (int i = 0; i < D; i++) m[i].v = 0;
        end else if (al_v && cnt < D) begin
            slot = -1;
            for (int i = 0; i < D; i++) if (!m[i].v && slot < 0) slot = i;
            m[slot].v = 1; m[slot].seq = seq_ctr++;
            m[slot].op = al_op; m[slot].dst = al_dst;
            m[slot].ar = al_ar; m[slot].at = al_at; m[slot].av = al_av;
            m[slot].br = al_br; m[slot].bt = al_bt; m[slot].bv = al_bv;
            if (cdb_v && !al_ar && al_at == cdb_t) begin m[slot].ar = 1; m[slot].av = cdb_d; end
            if (cdb_v && !al_br && al_bt == cdb_t) begin m[slot].br = 1; m[slot].bv = cdb_d; end
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        bit r;
        for (int i = 0; i < D; i++) m[i].v = 0;
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1");

        // R2 ready write, then R7 slot is freed
        put_alloc(4'h3, 4'h1, 1, 4'h0, 16'h1111, 1, 4'h0, 16'h2222);
        step("R2"); step("R2"); step("R7");

        // R3 wrong tag ignored, right tag captured; R4 half-ready does not issue
        put_alloc(4'h5, 4'h2, 0, 4'h5, 16'h0, 0, 4'h4, 16'h0);
        step("R3");
        put_cdb(4'h6, 16'hdead); step("R3");
        step("R3");
        put_cdb(4'h5, 16'habcd); step("R4");
        step("R4");
        put_cdb(4'h4, 16'h1234); step("R3");
        step("R3"); step("R7");

        // R5 broadcast in the same cycle as the write
        put_alloc(4'h7, 4'h3, 0, 4'h3, 16'h0, 1, 4'h0, 16'h5555);
        put_cdb(4'h3, 16'h7777);
        step("R5"); step("R5"); step("R5");

        // R6 and R10 one tag wakes three slots, two sharing a destination
        put_alloc(4'h1, 4'h1, 0, 4'h7, 16'h0, 1, 4'h0, 16'h0101); step("R10");
        put_alloc(4'h2, 4'h2, 1, 4'h0, 16'h0202, 0, 4'h7, 16'h0); step("R10");
        put_alloc(4'h3, 4'h2, 0, 4'h7, 16'h0, 0, 4'h7, 16'h0); step("R10");
        put_cdb(4'h7, 16'h4242); step("R10");
        step("R6"); step("R6"); step("R6"); step("R6");

        // R8 fill, write while full is dropped
        for (int i = 0; i < D; i++) begin
            put_alloc(4'(i), 4'(i + 8), 0, 4'h9, 16'h0, 1, 4'h0, 16'(i)); step("R8");
        end
        put_alloc(4'hf, 4'hf, 1, 4'h0, 16'hffff, 1, 4'h0, 16'hffff); step("R8");
        step("R8"); step("R8");
        put_cdb(4'h9, 16'h9999); step("R8");
        for (int i = 0; i < D + 2; i++) step("R8");

        // R9 flush with a write in the same cycle
        put_alloc(4'h1, 4'h4, 0, 4'ha, 16'h0, 1, 4'h0, 16'h1); step("R9");
        put_alloc(4'h2, 4'h5, 0, 4'ha, 16'h0, 1, 4'h0, 16'h2); step("R9");
        put_alloc(4'h3, 4'h6, 1, 4'h0, 16'h3, 1, 4'h0, 16'h3); flush = 1'b1; step("R9");
        put_cdb(4'ha, 16'haaaa); step("R9");
        step("R9"); step("R9");

        // random traffic with a small tag space
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(99) < 60)
                put_alloc(OW'($urandom), TW'($urandom),
                          $urandom_range(1) == 1, TW'($urandom_range(3)), DW'($urandom),
                          $urandom_range(1) == 1, TW'($urandom_range(3)), DW'($urandom));
            if ($urandom_range(1) == 1) put_cdb(TW'($urandom_range(3)), DW'($urandom));
            r = ($urandom_range(199) == 0);
            flush = r;
            step("R6");
        end
        for (int n = 0; n < 3; n++) begin
            put_cdb(TW'(n), DW'(n)); step("R7");
        end
        put_cdb(4'h3, 16'h3); step("R7");
        for (int n = 0; n < D + 2; n++) step("R7");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule